// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status-register and write-protection part of the serial slave in a NOR flash device. It watches an SPI mode 0 bus (chip select, serial clock and data in, all sampled by a faster system clock) and decodes one instruction per chip-select frame. A status-read instruction shifts the status byte out on the serial output. The byte repeats for as long as chip select stays low, so a host can poll the busy bit without opening a new frame.

Write-enable, write-disable, status-write, page-program, sector-erase and chip-erase instructions take effect when chip select rises, and only if the frame holds the right number of bits. Commands that change state need the write-enable latch. They are also screened against the block-protect zone, and the status write is screened against hardware protection: the stored lock bit set while the lock pin is low. An accepted command starts an internal timer whose length comes from an input. The busy bit stays set until the timer expires. On expiry the write-enable latch clears and, for program and erase, the error flag takes the value of a test input.

Top module: `sflash_status_ctrl`

## Requirements
- R1: After opcode 0x05 the status byte is shifted out MSB first, one bit per falling serial-clock edge, in the layout bit 0 busy, bit 1 write-enable latch, bits 4:2 protect zone (bit 2 is the low zone bit), bit 5 error flag, bit 6 always 0, bit 7 lock bit.
- R2: While chip select stays low after opcode 0x05, the current status byte is sent again and again.
- R3: After reset the serial output is low and the status reads 0x00 with the default parameters.
- R4: A frame of exactly 8 bits holding 0x06 sets the write-enable latch, and one holding 0x04 clears it. A frame with that opcode and any other bit count has no effect.
- R5: Status-write (0x01), page-program (0x02), sector-erase (0x20) and chip-erase (0xC7) frames are ignored while the write-enable latch is 0.
- R6: An accepted command sets the busy bit, which stays readable while set. It clears after op_len+1 clocks, and the write-enable latch clears with it.
- R7: While busy is 1 every instruction except the status read is ignored.
- R8: A 16-bit frame of 0x01 plus a data byte writes data bit 7 to the lock bit and data bits 4:2 to the zone, leaving the other status bits unchanged.
- R9: When the lock bit is 1 and hw_lock_n is low, a status write is rejected with no change to the status. When hw_lock_n is high, the same write is accepted.
- R10: Chip erase (an 8-bit frame) is accepted only when all three zone bits are 0.
- R11: Page program (at least 8+ADDR_W bits) and sector erase (exactly 8+ADDR_W bits) carry an MSB-first address. Its top BLK_W bits give the block b. With zone z nonzero, the command is rejected when z-1 >= BLK_W or b >= 2^BLK_W - 2^(z-1).
- R12: When a program or erase ends, the error flag takes the value of tst_fail (1 sets it, 0 clears it). Status writes and rejected commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select, one instruction per frame |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, low when no status read is active |
| hw_lock_n | input | 1 | Active-low pin that enables hardware protection when the lock bit is set |
| op_len | input | CNT_W | Timer load value for internal operations |
| tst_fail | input | 1 | Value given to the error flag when a program or erase ends |

## Verification
The bench builds the block with ADDR_W=16, BLK_W=3 and CNT_W=10, and drives op_len to 600. The shorter address keeps program and erase frames at 24 bits. With three block bits, each zone value falls on a block boundary that a single address byte can select. A 600-clock operation is long enough for a full status read, a write-disable and a status write to all land inside the busy window, so R6 and R7 are checked directly rather than only after the operation ends.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_WR_DIS     = 8'h04;
    localparam logic [7:0] OPC_RD_STAT    = 8'h05;
    localparam logic [7:0] OPC_WR_STAT    = 8'h01;
    localparam logic [7:0] OPC_PAGE_PROG  = 8'h02;
    localparam logic [7:0] OPC_SECT_ERASE = 8'h20;
    localparam logic [7:0] OPC_CHIP_ERASE = 8'hC7;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_STAT = 2'd1,
        KIND_PE   = 2'd2
    } op_kind_e;
endpackage

// File: rtl/sfsr_spi_rx.sv
module sfsr_spi_rx #(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 3,
    localparam int FRAME_BITS = 8 + ADDR_W,
    localparam int BC_W = $clog2(FRAME_BITS + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    output logic             sclk_fall,
    output logic             frame_end,
    output logic             op_ready,
    output logic [7:0]       opcode,
    output logic [7:0]       dbyte,
    output logic [BLK_W-1:0] blk,
    output logic [BC_W-1:0]  bit_cnt
);
    typedef struct packed {
        logic              sclk_s;
        logic              cs_s;
        logic [BC_W-1:0]   cnt;
        logic [ADDR_W-2:0] shreg;
        logic [7:0]        opcode;
        logic [7:0]        dbyte;
        logic [BLK_W-1:0]  blk;
        logic              op_rdy;
        logic              fall;
        logic              fend;
    } rx_t;

    rx_t q, d;
    logic [ADDR_W-1:0] nbit;

    always_comb begin
        d        = q;
        d.sclk_s = spi_sclk;
        d.cs_s   = spi_cs_n;
        d.op_rdy = 1'b0;
        d.fall   = 1'b0;
        d.fend   = 1'b0;
        nbit     = {q.shreg, spi_mosi};
        if (spi_cs_n) begin
            if (!q.cs_s) d.fend = 1'b1;
        end else if (q.cs_s) begin
            d.cnt = '0;
        end else if (spi_sclk && !q.sclk_s) begin
            d.shreg = nbit[ADDR_W-2:0];
            if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
            if (q.cnt == BC_W'(7)) begin
                d.opcode = nbit[7:0];
                d.op_rdy = 1'b1;
            end
            if (q.cnt == BC_W'(15)) d.dbyte = nbit[7:0];
            if (q.cnt == BC_W'(FRAME_BITS - 1)) d.blk = nbit[ADDR_W-1 -: BLK_W];
        end else if (!spi_sclk && q.sclk_s) begin
            d.fall = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_s   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_fall = q.fall;
    assign frame_end = q.fend;
    assign op_ready  = q.op_rdy;
    assign opcode    = q.opcode;
    assign dbyte     = q.dbyte;
    assign blk       = q.blk;
    assign bit_cnt   = q.cnt;
endmodule

// File: rtl/sfsr_zone_map.sv
module sfsr_zone_map #(
    parameter int BLK_W = 3,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [2:0]       zone,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    int zi;

    always_comb begin
        zi  = int'(zone);
        hit = 1'b0;
        if (zi != 0) begin
            if (zi - 1 >= BLK_W) hit = 1'b1;
            else hit = (int'(blk) >= NBLK - (1 << (zi - 1)));
        end
    end
endmodule

// File: rtl/sfsr_stat_tx.sv
module sfsr_stat_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       start,
    input  logic       sclk_fall,
    input  logic [7:0] status,
    output logic       spi_miso
);
    typedef struct packed {
        logic       active;
        logic [2:0] idx;
        logic [7:0] shreg;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (spi_cs_n) begin
            d.active = 1'b0;
            d.idx    = '0;
        end else if (start) begin
            d.active = 1'b1;
            d.idx    = '0;
            d.shreg  = '0;
        end else if (q.active && sclk_fall) begin
            if (q.idx == 3'd0) d.shreg = status;
            else d.shreg = {q.shreg[6:0], 1'b0};
            d.idx = q.idx + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else q <= d;
    end

    assign spi_miso = q.active & q.shreg[7];

    // a new byte always starts from a fresh snapshot (R2)
    assert_byte_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !spi_cs_n && !start && sclk_fall && q.idx == 3'd0) |=> (q.shreg == $past(status)));
endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
    import sfsr_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter int         BLK_W     = 3,
    parameter int         CNT_W     = 16,
    parameter logic [2:0] INIT_ZONE = 3'b000,
    parameter logic       INIT_LOCK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic             hw_lock_n,
    input  logic [CNT_W-1:0] op_len,
    input  logic             tst_fail
);
    localparam int FRAME_BITS = 8 + ADDR_W;
    localparam int BC_W = $clog2(FRAME_BITS + 1) + 1;

    typedef struct packed {
        logic             busy;
        logic             wlatch;
        logic [2:0]       zone;
        logic             lock;
        logic             fail;
        op_kind_e         kind;
        logic [CNT_W-1:0] timer;
    } st_t;

    st_t q, d;

    logic             sclk_fall, frame_end, op_ready, zone_hit, hw_locked, rd_start;
    logic [7:0]       opcode, dbyte, stat;
    logic [BLK_W-1:0] blk;
    logic [BC_W-1:0]  bit_cnt;

    sfsr_spi_rx #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .sclk_fall(sclk_fall), .frame_end(frame_end),
        .op_ready(op_ready), .opcode(opcode), .dbyte(dbyte), .blk(blk),
        .bit_cnt(bit_cnt)
    );

    sfsr_zone_map #(.BLK_W(BLK_W)) zmap_i (
        .zone(q.zone), .blk(blk), .hit(zone_hit)
    );

    assign stat     = {q.lock, 1'b0, q.fail, q.zone, q.wlatch, q.busy};
    assign rd_start = op_ready && (opcode == OPC_RD_STAT);

    sfsr_stat_tx tx_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .start(rd_start),
        .sclk_fall(sclk_fall), .status(stat), .spi_miso(spi_miso)
    );

    assign hw_locked = q.lock && !hw_lock_n;

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.timer == '0) begin
                d.busy   = 1'b0;
                d.wlatch = 1'b0;
                if (q.kind == KIND_PE) d.fail = tst_fail;
                d.kind   = KIND_NONE;
            end else begin
                d.timer = q.timer - 1'b1;
            end
        end else if (frame_end) begin
            unique case (opcode)
                OPC_WR_EN:  if (bit_cnt == BC_W'(8)) d.wlatch = 1'b1;
                OPC_WR_DIS: if (bit_cnt == BC_W'(8)) d.wlatch = 1'b0;
                OPC_WR_STAT: begin
                    if (bit_cnt == BC_W'(16) && q.wlatch && !hw_locked) begin
                        d.lock  = dbyte[7];
                        d.zone  = dbyte[4:2];
                        d.busy  = 1'b1;
                        d.kind  = KIND_STAT;
                        d.timer = op_len;
                    end
                end
                OPC_PAGE_PROG, OPC_SECT_ERASE: begin
                    if (q.wlatch && !zone_hit &&
                        ((opcode == OPC_PAGE_PROG  && bit_cnt >= BC_W'(FRAME_BITS)) ||
                         (opcode == OPC_SECT_ERASE && bit_cnt == BC_W'(FRAME_BITS)))) begin
                        d.busy  = 1'b1;
                        d.kind  = KIND_PE;
                        d.timer = op_len;
                    end
                end
                OPC_CHIP_ERASE: begin
                    if (bit_cnt == BC_W'(8) && q.wlatch && q.zone == 3'b000) begin
                        d.busy  = 1'b1;
                        d.kind  = KIND_PE;
                        d.timer = op_len;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.zone <= INIT_ZONE;
            q.lock <= INIT_LOCK;
        end else begin
            q <= d;
        end
    end

    logic       busy_w, wlatch_w, lock_w, fail_w;
    logic [2:0] zone_w;
    assign busy_w   = q.busy;
    assign wlatch_w = q.wlatch;
    assign lock_w   = q.lock;
    assign fail_w   = q.fail;
    assign zone_w   = q.zone;

    assert_start_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> $past(wlatch_w));

    assert_latch_drops_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> !wlatch_w);

    assert_busy_freezes_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |=> ($stable(lock_w) && $stable(zone_w)));

    assert_hw_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_w && !hw_lock_n) |=> ($stable(lock_w) && $stable(zone_w)));

    assert_chip_erase_clear_zone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_w) && $past(opcode) == OPC_CHIP_ERASE) |-> ($past(zone_w) == 3'b000));

    assert_fail_only_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail_w) |-> $fell(busy_w));
endmodule

// File: tb/sflash_status_ctrl_tb.sv
module sflash_status_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int ADDR_W     = 16;
    localparam int BLK_W      = 3;
    localparam int CNT_W      = 10;
    localparam int NVEC       = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso;
    logic hw_lock_n = 1'b1;
    logic [CNT_W-1:0] op_len = CNT_W'(600);
    logic tst_fail = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_status_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .hw_lock_n(hw_lock_n),
        .op_len(op_len), .tst_fail(tst_fail)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] arg;
        logic        wren;
        logic        hw_n;
        logic        fail_in;
        logic [7:0]  expv;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h06, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h02, 4'd4},  // R4 latch set
        '{8'h04, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 latch clear
        '{8'h02, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 4'd5},  // R5 no latch
        '{8'h02, 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00, 4'd6},  // R6 latch cleared at end
        '{8'h20, 16'h1000, 1'b1, 1'b1, 1'b1, 8'h20, 4'd12}, // R12 error set
        '{8'h20, 16'h1000, 1'b1, 1'b1, 1'b0, 8'h00, 4'd12}, // R12 retry clears
        '{8'h02, 16'h2000, 1'b1, 1'b1, 1'b1, 8'h20, 4'd12}, // R12 error set
        '{8'h01, 16'h00FF, 1'b1, 1'b1, 1'b0, 8'hBC, 4'd8},  // R8 only 7,4:2; bit6 zero (R1)
        '{8'hC7, 16'h0000, 1'b1, 1'b1, 1'b0, 8'hBE, 4'd10}, // R10 zone set blocks
        '{8'h04, 16'h0000, 1'b0, 1'b1, 1'b0, 8'hBC, 4'd4},  // R4
        '{8'h01, 16'h0000, 1'b1, 1'b0, 1'b0, 8'hBE, 4'd9},  // R9 hardware locked
        '{8'h01, 16'h0088, 1'b0, 1'b1, 1'b0, 8'hA8, 4'd9},  // R9 pin high, accepted
        '{8'h02, 16'hC000, 1'b1, 1'b1, 1'b0, 8'hAA, 4'd11}, // R11 block 6 protected
        '{8'h02, 16'hA000, 1'b0, 1'b1, 1'b0, 8'h88, 4'd11}, // R11 block 5 open
        '{8'h01, 16'h000C, 1'b1, 1'b1, 1'b0, 8'h0C, 4'd8},  // R8
        '{8'h20, 16'h8000, 1'b1, 1'b1, 1'b0, 8'h0E, 4'd11}, // R11 block 4 protected
        '{8'h20, 16'h6000, 1'b0, 1'b1, 1'b1, 8'h2C, 4'd11}, // R11 block 3 open
        '{8'h01, 16'h0000, 1'b1, 1'b0, 1'b0, 8'h20, 4'd9},  // R9 lock bit 0, pin low
        '{8'hC7, 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00, 4'd10}, // R10 zone clear
        '{8'h02, 16'hE000, 1'b1, 1'b1, 1'b0, 8'h00, 4'd11}  // R11 zone 0
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            tick(HALF);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_open;
        spi_cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_close;
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [15:0] arg);
        logic [7:0] dummy;
        frame_open();
        spi_byte(op, dummy);
        if (op == 8'h01) spi_byte(arg[7:0], dummy);
        if (op == 8'h02 || op == 8'h20) begin
            spi_byte(arg[15:8], dummy);
            spi_byte(arg[7:0], dummy);
        end
        frame_close();
    endtask

    task automatic read_stat(output logic [7:0] v);
        logic [7:0] dummy;
        frame_open();
        spi_byte(8'h05, dummy);
        spi_byte(8'h00, v);
        frame_close();
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        bit done = 1'b0;
        for (int k = 0; k < 40 && !done; k++) begin
            read_stat(v);
            if (!v[0]) done = 1'b1;
        end
        if (!done) check(tag, v, {v[7:1], 1'b0});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] v, dummy;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R3 reset state
        check("R3 miso idle", {7'd0, spi_miso}, 8'h00);
        read_stat(v);
        check("R3 status after reset", v, 8'h00);

        // table walk
        for (int n = 0; n < NVEC; n++) begin
            hw_lock_n = VECS[n].hw_n;
            tst_fail  = VECS[n].fail_in;
            if (VECS[n].wren) send_cmd(8'h06, 16'h0000);
            send_cmd(VECS[n].op, VECS[n].arg);
            wait_idle($sformatf("R6 idle vec %0d", n));
            read_stat(v);
            check($sformatf("R%0d vec %0d", VECS[n].req, n), v, VECS[n].expv);
        end
        hw_lock_n = 1'b1;
        tst_fail  = 1'b0;

        // R4 wrong frame length ignored
        frame_open();
        spi_byte(8'h06, dummy);
        spi_byte(8'h00, dummy);
        frame_close();
        read_stat(v);
        check("R4 16-bit enable frame ignored", v, 8'h00);

        // R6 / R7 busy window
        send_cmd(8'h06, 16'h0000);
        send_cmd(8'h20, 16'h0000);
        read_stat(v);
        check("R6 busy readable", v, 8'h03);
        send_cmd(8'h04, 16'h0000);
        read_stat(v);
        check("R7 disable ignored while busy", v, 8'h03);
        send_cmd(8'h01, 16'h009C);
        wait_idle("R6 busy ends");
        read_stat(v);
        check("R7 status write ignored while busy", v, 8'h00);

        // R2 repeated status while select held, R1 shifting
        send_cmd(8'h06, 16'h0000);
        frame_open();
        spi_byte(8'h05, dummy);
        for (int b = 0; b < 3; b++) begin
            spi_byte(8'h00, v);
            check($sformatf("R2 repeat byte %0d", b), v, 8'h02);
        end
        frame_close();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule